// File: doc/BRIEF.md
# Entropy Word Generator with Seed-Fault Recovery

The block turns a serial stream of raw entropy bits into 32-bit random words. A small register file on a 32-bit word bus serves as its interface. Bits are shifted in on ticks of a programmable divider. Completed words queue in a four-entry buffer, and a ready flag in the status register announces them. Software reads words from the data offset.

Two fault sources come from outside the block. A seed-fault input stands in for a failing noise source. A slow-clock input stands in for a generator clock that runs too slowly. A seed fault halts generation and flushes the buffer. It raises both an event flag and a live-condition flag. Software leaves the fault through a conditional-reset handshake: it writes the reset bit high and then low. Hardware keeps the bit high until a fixed internal window has elapsed. If the fault input drops without help from software, the block runs the same window by itself and leaves only the event flag set.

The controller is a four-state machine:
- IDLE: generation disabled.
- RUN: words are produced.
- FAULT: a seed fault is pending.
- CRST: the conditional-reset window.

Its transitions are:
- IDLE to RUN when enabled.
- RUN to IDLE when disabled.
- RUN to FAULT on a seed fault.
- Any state except CRST to CRST when software raises the reset bit.
- FAULT to CRST by auto-recovery once the fault input falls.
- CRST to FAULT, RUN or IDLE when the window ends. The choice depends on the fault input and the enable bit.

Top module: `entropy_ctrl`

## Requirements
- R1: After reset, the control, status, data, noise-control and health registers all read 0.
- R2: The noise-control register (offset 0x0C) keeps only bits 17:0, and its upper bits read 0. The health register (offset 0x10) stores all 32 bits.
- R3: Control offset 0x00 layout:
  - bit 2: enable.
  - bit 5: clock-check disable.
  - bits 25:8: configuration. Bits 19:16 are the divider exponent.
  - bit 30: conditional reset.
  The configuration fields change only on a write that sets bit 30 or while bit 30 reads 1. Enable follows every write.
- R4: Software raises bit 30 and then writes it low. Bit 30 keeps reading 1 until 16 generator ticks after that release write, and then clears by itself.
- R5: Status offset 0x04 bit 0 (ready) reads 1 whenever the buffer holds a word in RUN. A data read (offset 0x08) returns the oldest word. Words are built from 32 ticks with the newest bit at bit 0, so a stream of constant ones gives 0xFFFFFFFF.
- R6: The buffer holds four words. When it is full, the shifter stalls. Four back-to-back data reads empty it, and ready drops after the fourth.
- R7: A seed fault in RUN sets status bit 6 (event) and bit 2 (live condition). It clears ready and stops generation.
- R8: A data read returns 0 when no word is available, including during a seed fault.
- R9: Software recovery works as follows:
  - Raising bit 30 clears status bit 6 at once.
  - Status bit 2 clears when the window ends.
  - After that, generation resumes.
- R10: When the fault input falls while in FAULT, the block recovers by itself after 16 ticks. Status bit 2 clears and bit 6 stays set.
- R11: Status bits 6 and 5 are write-0-to-clear. Writing 1 leaves them unchanged. Bits 2 and 0 ignore writes.
- R12: The slow-clock input sets status bit 5 only while enable is 1 and control bit 5 is 0.
- R13: A control write of all zeros stops generation, flushes the buffer and clears ready. The configuration fields are kept.
- R14: The generator ticks once every 2^exponent clock cycles, so exponent 2 stretches the reset window to 64 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data read pops a word) |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| noise_bit | input | 1 | Raw entropy bit |
| seed_fault | input | 1 | Seed-fault condition from the noise source |
| clk_slow | input | 1 | Generator clock too slow |

## Verification
The bench checks that the reset bit stays high for the whole window at exponents 0 and 2. A design that cleared it on the release write, or ignored the divider, would show a low bit too early or a high bit too late. It tells the two recovery paths apart by the event flag. A design that cleared the event flag on auto-recovery, or kept it on software recovery, would fail there. It fills the buffer to four words and drains it with back-to-back reads, which catches an off-by-one depth or a shifter that overruns. It then mixes random slow-clock pulses, write-0-to-clear writes and clock-check reconfigurations against a bench model of the clock-error flag. It also confirms that configuration writes made without the reset bit are ignored.

// File: rtl/entropy_pkg.sv
package entropy_pkg;
    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_STAT   = 5'h04;
    localparam logic [4:0] OFS_DATA   = 5'h08;
    localparam logic [4:0] OFS_NOISE  = 5'h0C;
    localparam logic [4:0] OFS_HEALTH = 5'h10;

    localparam int CTL_EN     = 2;
    localparam int CTL_CED    = 5;
    localparam int CTL_DIV_LO = 16;
    localparam int CTL_CRST   = 30;

    localparam int STS_DRDY = 0;
    localparam int STS_SECS = 2;
    localparam int STS_CEIS = 5;
    localparam int STS_SEIS = 6;

    localparam logic [31:0] CFG_MASK = 32'h03FF_FF20;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2,
        ST_CRST  = 2'd3
    } gen_state_e;
endpackage

// File: rtl/ent_divider.sv
module ent_divider #(
    parameter int EXP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_i,
    output logic             tick_o
);
    localparam int CW = (1 << EXP_W) - 1;

    logic [CW-1:0] cnt_q;
    logic [CW:0]   mask_w;

    assign mask_w = ({{CW{1'b0}}, 1'b1} << exp_i) - 1'b1;
    assign tick_o = (cnt_q & mask_w[CW-1:0]) == mask_w[CW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // R14: with a nonzero exponent two ticks never come back to back
    p_tick_spacing_r14: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && exp_i != '0) |=> (!tick_o || !$stable(exp_i)));
endmodule

// File: rtl/ent_packer.sv
module ent_packer #(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          shift_i,
    input  logic          bit_i,
    output logic [WW-1:0] word_o,
    output logic          valid_o
);
    localparam int CW = $clog2(WW);

    logic [WW-1:0] sr_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q    <= '0;
            cnt_q   <= '0;
            word_o  <= '0;
            valid_o <= 1'b0;
        end else if (clear_i) begin
            cnt_q   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (shift_i) begin
                sr_q  <= {sr_q[WW-2:0], bit_i};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(WW - 1)) begin
                    word_o  <= {sr_q[WW-2:0], bit_i};
                    valid_o <= 1'b1;
                end
            end
        end
    end

    // R5: a finished word always follows a shift
    p_word_after_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(shift_i));
endmodule

// File: rtl/ent_fifo.sv
module ent_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;

    assign empty_o = (cnt_q == '0);
    assign full_o  = (cnt_q == (AW+1)'(DEPTH));
    assign dout_o  = mem_q[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (flush_i) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) begin
                mem_q[wp_q] <= din_i;
                wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            end
            if (pop_i) rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q <= cnt_q + (push_i ? 1'b1 : 1'b0) - (pop_i ? 1'b1 : 1'b0);
        end
    end

    // R6: the shifter stall keeps pushes away from a full buffer
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i) |-> !full_o);
    // R8: no word is taken from an empty buffer
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/entropy_ctrl.sv
module entropy_ctrl
    import entropy_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int BUF_DEPTH  = 4,
    parameter int DIV_W      = 4,
    parameter int CRST_TICKS = 16,
    parameter int NOISE_W    = 18
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        noise_bit,
    input  logic        seed_fault,
    input  logic        clk_slow
);
    localparam int CNT_W = $clog2(CRST_TICKS + 1);

    gen_state_e state_q, state_d;

    logic [31:0]        ctrl_q, ctrl_d;
    logic [NOISE_W-1:0] nscr_q;
    logic [31:0]        htcr_q;
    logic               seis_q, ceis_q, secs_q, crst_rel_q;
    logic [CNT_W-1:0]   crst_cnt_q;

    logic ctrl_wr, stat_wr, noise_wr, health_wr, data_rd;
    logic held, en_now, run;
    logic crst_start_sw, crst_release, crst_done, fault_entry, auto_entry;
    logic tick, word_valid, fifo_empty, fifo_full, drdy, shift, pop;
    logic [WORD_W-1:0] word, fifo_dout;

    assign ctrl_wr   = bus_wr && (bus_addr == OFS_CTRL);
    assign stat_wr   = bus_wr && (bus_addr == OFS_STAT);
    assign noise_wr  = bus_wr && (bus_addr == OFS_NOISE);
    assign health_wr = bus_wr && (bus_addr == OFS_HEALTH);
    assign data_rd   = bus_rd && (bus_addr == OFS_DATA);

    assign held   = ctrl_q[CTL_CRST];
    assign en_now = ctrl_q[CTL_EN];
    assign run    = (state_q == ST_RUN);

    assign crst_start_sw = ctrl_wr && bus_wdata[CTL_CRST] && !held;
    assign crst_release  = ctrl_wr && !bus_wdata[CTL_CRST] && held;
    assign crst_done     = (state_q == ST_CRST) && crst_rel_q && tick &&
                           (crst_cnt_q == CNT_W'(CRST_TICKS - 1));
    assign fault_entry   = (state_d == ST_FAULT) && (state_q != ST_FAULT);
    assign auto_entry    = (state_q == ST_FAULT) && (state_d == ST_CRST) && !crst_start_sw;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (crst_start_sw)    state_d = ST_CRST;
                      else if (en_now)      state_d = ST_RUN;
            ST_RUN:   if (crst_start_sw)    state_d = ST_CRST;
                      else if (seed_fault)  state_d = ST_FAULT;
                      else if (!en_now)     state_d = ST_IDLE;
            ST_FAULT: if (crst_start_sw || !seed_fault) state_d = ST_CRST;
            ST_CRST:  if (crst_done)        state_d = seed_fault ? ST_FAULT :
                                                      (en_now ? ST_RUN : ST_IDLE);
            default:                        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // control register update
    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr) begin
            if (bus_wdata[CTL_CRST] || held)
                ctrl_d = (ctrl_q & ~CFG_MASK) | (bus_wdata & CFG_MASK);
            ctrl_d[CTL_EN]   = bus_wdata[CTL_EN];
            ctrl_d[CTL_CRST] = held || bus_wdata[CTL_CRST];
        end
        if (crst_done) ctrl_d[CTL_CRST] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            nscr_q     <= '0;
            htcr_q     <= '0;
            seis_q     <= 1'b0;
            secs_q     <= 1'b0;
            ceis_q     <= 1'b0;
            crst_rel_q <= 1'b0;
            crst_cnt_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            if (noise_wr)  nscr_q <= bus_wdata[NOISE_W-1:0];
            if (health_wr) htcr_q <= bus_wdata;

            if (fault_entry)                             seis_q <= 1'b1;
            else if (crst_start_sw)                      seis_q <= 1'b0;
            else if (stat_wr && !bus_wdata[STS_SEIS])    seis_q <= 1'b0;

            if (fault_entry)    secs_q <= 1'b1;
            else if (crst_done) secs_q <= 1'b0;

            if (clk_slow && en_now && !ctrl_q[CTL_CED])  ceis_q <= 1'b1;
            else if (stat_wr && !bus_wdata[STS_CEIS])    ceis_q <= 1'b0;

            if (crst_start_sw)                   crst_rel_q <= 1'b0;
            else if (crst_release || auto_entry) crst_rel_q <= 1'b1;

            if (state_q != ST_CRST || crst_start_sw) crst_cnt_q <= '0;
            else if (crst_rel_q && tick)             crst_cnt_q <= crst_cnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        drdy  = run && !fifo_empty;
        shift = tick && run && !fifo_full;
        pop   = data_rd && drdy;
        unique case (bus_addr)
            OFS_CTRL:   bus_rdata = ctrl_q;
            OFS_STAT:   bus_rdata = {25'd0, seis_q, ceis_q, 2'b00, secs_q, 1'b0, drdy};
            OFS_DATA:   bus_rdata = drdy ? 32'(fifo_dout) : 32'd0;
            OFS_NOISE:  bus_rdata = 32'(nscr_q);
            OFS_HEALTH: bus_rdata = htcr_q;
            default:    bus_rdata = 32'd0;
        endcase
    end

    ent_divider #(.EXP_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n),
        .exp_i(ctrl_q[CTL_DIV_LO +: DIV_W]),
        .tick_o(tick)
    );

    ent_packer #(.WW(WORD_W)) pack_i (
        .clk(clk), .rst_n(rst_n), .clear_i(!run), .shift_i(shift),
        .bit_i(noise_bit), .word_o(word), .valid_o(word_valid)
    );

    ent_fifo #(.W(WORD_W), .DEPTH(BUF_DEPTH)) buf_i (
        .clk(clk), .rst_n(rst_n), .flush_i(!run), .push_i(word_valid),
        .din_i(word), .pop_i(pop), .dout_o(fifo_dout),
        .empty_o(fifo_empty), .full_o(fifo_full)
    );

    // R7: while a fault is pending the live flag is up and nothing is ready
    p_fault_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |-> (secs_q && !drdy));
    // R7: the live flag never rises without the event flag
    p_fault_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(secs_q) |-> seis_q);
    // R4: the reset bit stays up for as long as the window is running
    p_crst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ctrl_q[CTL_CRST]) && state_q == ST_CRST) |-> ctrl_q[CTL_CRST]);
    // R4: the reset bit only falls at the end of a window
    p_crst_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q[CTL_CRST]) |-> ($past(state_q) == ST_CRST));
endmodule

// File: tb/entropy_ctrl_tb_top.sv
module entropy_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        noise_bit = 1'b1, seed_fault = 1'b0, clk_slow = 1'b0;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] EN   = 32'h0000_0004;
    localparam logic [31:0] CRST = 32'h4000_0000;
    localparam logic [31:0] CED  = 32'h0000_0020;

    always #5 clk = ~clk;

    entropy_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .noise_bit(noise_bit), .seed_fault(seed_fault), .clk_slow(clk_slow)
    );

    function automatic logic [31:0] exp_word();
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] exp_status(bit seis, bit ceis, bit secs, bit drdy);
        return {25'd0, seis, ceis, 2'b00, secs, 1'b0, drdy};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_slow();
        @(negedge clk); clk_slow = 1'b1;
        @(negedge clk); clk_slow = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        bit ceis_m, ced_m;
        void'($urandom(32'd7177));
        wait_cyc(3);
        rst_n = 1'b1;

        // R1 reset values
        bus_read(5'h00, r); check("R1 ctrl", r, 0);
        bus_read(5'h04, r); check("R1 status", r, 0);
        bus_read(5'h08, r); check("R1 data", r, 0);
        bus_read(5'h0C, r); check("R1 noise", r, 0);
        bus_read(5'h10, r); check("R1 health", r, 0);

        // R2 noise control width, health full width
        bus_write(5'h0C, 32'hFFFF_FFFF);
        bus_read(5'h0C, r); check("R2 noise", r, 32'h0003_FFFF);
        bus_write(5'h10, 32'h1234_ABCD);
        bus_read(5'h10, r); check("R2 health", r, 32'h1234_ABCD);

        // R3 config ignored without conditional reset
        bus_write(5'h00, EN | (32'd3 << 16) | (32'hA << 8));
        bus_read(5'h00, r); check("R3 cfg locked", r, EN);
        bus_write(5'h00, 0);

        // R3 R4 R14 config under reset, window at exponent 2
        bus_write(5'h00, CRST | (32'd2 << 16) | (32'hD << 8));
        bus_read(5'h00, r); check("R3 cfg open", r, CRST | (32'd2 << 16) | (32'hD << 8));
        bus_write(5'h00, EN | (32'd2 << 16) | (32'hD << 8));
        wait_cyc(46);
        bus_read(5'h00, r); check("R14 crst held at div 2", r[30], 1);
        wait_cyc(30);
        bus_read(5'h00, r); check("R14 crst cleared at div 2", r, EN | (32'd2 << 16) | (32'hD << 8));

        // R4 window at exponent 0
        bus_write(5'h00, CRST);
        bus_write(5'h00, EN);
        wait_cyc(8);
        bus_read(5'h00, r); check("R4 crst held", r[30], 1);
        wait_cyc(16);
        bus_read(5'h00, r); check("R4 crst self-clear", r, EN);

        // R5 first word
        wait_cyc(40);
        bus_read(5'h04, r); check("R5 ready", r, exp_status(0, 0, 0, 1));
        bus_read(5'h08, r); check("R5 word", r, exp_word());

        // R6 four-word buffer
        wait_cyc(200);
        bus_read(5'h08, r); check("R6 word 1", r, exp_word());
        bus_read(5'h08, r); check("R6 word 2", r, exp_word());
        bus_read(5'h08, r); check("R6 word 3", r, exp_word());
        bus_read(5'h08, r); check("R6 word 4", r, exp_word());
        bus_read(5'h04, r); check("R6 drained", r[0], 0);
        bus_read(5'h08, r); check("R8 empty read", r, 0);

        // R7 seed fault
        wait_cyc(200);
        @(negedge clk); seed_fault = 1'b1;
        wait_cyc(2);
        bus_read(5'h04, r); check("R7 fault flags", r, exp_status(1, 0, 1, 0));
        bus_read(5'h08, r); check("R8 read in fault", r, 0);

        // R9 software recovery
        bus_write(5'h00, CRST);
        bus_read(5'h04, r); check("R9 event cleared on entry", r, exp_status(0, 0, 1, 0));
        @(negedge clk); seed_fault = 1'b0;
        bus_write(5'h00, EN);
        wait_cyc(24);
        bus_read(5'h04, r); check("R9 live cleared", r & 32'h44, 0);
        wait_cyc(60);
        bus_read(5'h08, r); check("R9 generation resumed", r, exp_word());

        // R10 auto recovery
        @(negedge clk); seed_fault = 1'b1;
        @(negedge clk); seed_fault = 1'b0;
        wait_cyc(1);
        bus_read(5'h04, r); check("R10 flags during window", r, exp_status(1, 0, 1, 0));
        wait_cyc(24);
        bus_read(5'h04, r); check("R10 event kept, live cleared", r & 32'h44, 32'h40);
        bus_read(5'h00, r); check("R10 reset bit untouched", r[30], 0);

        // R11 write-0-to-clear
        bus_write(5'h04, 32'hFFFF_FFFF);
        bus_read(5'h04, r); check("R11 write 1 keeps", r[6], 1);
        bus_write(5'h04, 32'hFFFF_FFBF);
        bus_read(5'h04, r); check("R11 write 0 clears", r[6], 0);

        // R12 clock error gating
        pulse_slow();
        bus_read(5'h04, r); check("R12 clock error set", r[5], 1);
        bus_write(5'h04, 32'hFFFF_FFDF);
        bus_read(5'h04, r); check("R11 clock error cleared", r[5], 0);
        bus_write(5'h00, CRST | CED);
        bus_write(5'h00, CED | EN);
        wait_cyc(24);
        pulse_slow();
        bus_read(5'h04, r); check("R12 detection disabled", r[5], 0);

        // R13 all-zero control write
        wait_cyc(200);
        bus_read(5'h04, r); check("R13 ready before", r[0], 1);
        bus_write(5'h00, 0);
        wait_cyc(3);
        bus_read(5'h04, r); check("R13 ready cleared", r[0], 0);
        bus_read(5'h08, r); check("R13 data flushed", r, 0);
        bus_read(5'h00, r); check("R13 config kept", r, CED);

        // random phase
        bus_write(5'h00, CED | EN);
        ced_m = 1'b1; ceis_m = 1'b0;
        for (int it = 0; it < 80; it++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: wait_cyc($urandom_range(0, 40));
                1: begin
                    bus_read(5'h04, r);
                    check("R12 random clock flag", r[5], ceis_m);
                    check("R7 random no fault", r & 32'h44, 0);
                    if (r[0]) begin
                        bus_read(5'h08, r);
                        check("R5 random word", r, exp_word());
                    end
                end
                2: begin
                    pulse_slow();
                    if (!ced_m) ceis_m = 1'b1;
                end
                3: begin
                    logic [31:0] c;
                    c = ($urandom_range(0, 1) != 0) ? CED : 32'd0;
                    bus_write(5'h00, CRST | c);
                    bus_write(5'h00, c | EN);
                    wait_cyc(24);
                    ced_m = (c != 0);
                end
                default: begin
                    logic [31:0] w;
                    w = $urandom;
                    bus_write(5'h04, w);
                    if (!w[5]) ceis_m = 1'b0;
                end
            endcase
        end
        bus_read(5'h04, r); check("R11 final clock flag", r[5], ceis_m);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule